// File: doc/BRIEF.md
# Software-Refilled Partitioned Translation Buffer

This block is a fully associative translation lookaside buffer whose contents are loaded by software. All entries are compared against a lookup at the same time. A run-time boundary splits the array into a protected lower region and a replaceable upper region. The lower region holds translations that are costly to rebuild, such as the mappings of page-table pages. The upper region holds ordinary translations and is refilled at a rotating victim index.

A lookup carries a virtual page number, an address-space identifier, a write flag and an access context. The context tells a plain user or kernel access apart from a nested page-table fetch, which is issued while a user or kernel miss is being serviced. A hit returns the physical frame. A failed lookup returns a vector code that names the kind of fault, so that each kind can go to its own handler. Software writes entries either at an explicit index or at the current victim index. Two flush inputs clear the valid bits, either of every entry or of the non-global entries that belong to one address space.

Top module: `ptlb_top`

## Requirements
- R1: After reset every entry has cleared fields and is invalid, `rsp_vld` is 0 and the victim index is the last entry, 63. A lookup of page 0 with identifier 0 then returns vector 6.
- R2: An entry matches a lookup when its page number equals `lk_vpn` and either its global bit is set or its identifier equals `lk_asid`. A lookup that matches exactly one valid entry, and is not a write to a non-writable entry, returns `rsp_hit`=1, that entry's frame on `rsp_pfn` and `rsp_vec`=0.
- R3: A lookup that matches no entry returns `rsp_hit`=0 and a vector chosen by `lk_ctx`. Context 0 (user) gives 1, context 1 (kernel) gives 2, context 2 (nested fetch for a user miss) gives 3, and context 3 (nested fetch for a kernel miss) gives 4.
- R4: A write lookup (`lk_write`=1) that matches exactly one valid entry whose writable bit is 0 returns vector 5 and no hit. A read lookup never returns vector 5.
- R5: A lookup that matches no valid entry but matches at least one invalid entry returns vector 6, a page fault.
- R6: A lookup that matches two or more valid entries returns vector 7 and `rsp_hit`=0.
- R7: A write with `wr_random`=0 stores all entry fields at `wr_idx`. Any index is accepted, including those in the lower region.
- R8: A write with `wr_random`=1 stores at the victim index. The victim index decrements by one on every clock. In the cycle after it has held the value `lower_slots`, or any smaller value, it reloads to 63, so random writes never land below `lower_slots`.
- R9: `flush_all` clears every valid bit in one cycle. A write in the same cycle still takes effect.
- R10: `flush_asid` clears the valid bit of every non-global entry whose identifier equals `flush_asid_id`. Global entries and entries with other identifiers are kept.
- R11: Results are registered. `rsp_vld` is 1 exactly one cycle after a cycle with `lk_req`=1 and is 0 otherwise. A lookup sees the array as it was before any write or flush in the same cycle.
- R12: A non-global entry whose identifier differs from `lk_asid` does not match, even when its page number is equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lower_slots | input | 6 | Size of the protected lower region |
| lk_req | input | 1 | Lookup request |
| lk_vpn | input | 20 | Lookup virtual page number |
| lk_asid | input | 8 | Lookup address-space identifier |
| lk_write | input | 1 | Lookup is a store |
| lk_ctx | input | 2 | Access context: 0 user, 1 kernel, 2 nested for user, 3 nested for kernel |
| wr_en | input | 1 | Entry write strobe |
| wr_random | input | 1 | Write at the victim index instead of `wr_idx` |
| wr_idx | input | 6 | Explicit write index |
| wr_vpn | input | 20 | Page number to store |
| wr_asid | input | 8 | Identifier to store |
| wr_global | input | 1 | Global bit to store |
| wr_pfn | input | 20 | Frame number to store |
| wr_valid | input | 1 | Valid bit to store |
| wr_dirty | input | 1 | Writable bit to store |
| flush_all | input | 1 | Clear every valid bit |
| flush_asid | input | 1 | Clear valid bits of non-global entries of one identifier |
| flush_asid_id | input | 8 | Identifier for `flush_asid` |
| rsp_vld | output | 1 | Result valid |
| rsp_hit | output | 1 | Translation found |
| rsp_pfn | output | 20 | Physical frame on a hit |
| rsp_vec | output | 3 | Vector code, 0 on a hit |

## Verification
Every lookup result is due at the first rising edge after the request. The bench drives a request at a falling edge and compares `rsp_vld`, `rsp_hit`, `rsp_pfn` and `rsp_vec` at the next falling edge, against a value its model computed from the array as it stood before that edge. Writes and flushes take effect at that same edge, so a lookup one cycle later is the earliest that sees them. The model's victim counter steps once per clock from the end of reset, so the landing index of each random write is known exactly, and later lookups confirm where each write went.

// File: rtl/ptlb_pkg.sv
package ptlb_pkg;

    localparam int VPN_W  = 20;
    localparam int ASID_W = 8;
    localparam int PFN_W  = 20;

    typedef struct packed {
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
        logic              glob;
        logic [PFN_W-1:0]  pfn;
        logic              valid;
        logic              dirty;
    } tlb_ent_t;

    typedef enum logic [1:0] {
        CTX_USER   = 2'd0,
        CTX_KERN   = 2'd1,
        CTX_NEST_U = 2'd2,
        CTX_NEST_K = 2'd3
    } acc_ctx_e;

    typedef enum logic [2:0] {
        VEC_NONE  = 3'd0,
        VEC_L1U   = 3'd1,
        VEC_L1K   = 3'd2,
        VEC_L2    = 3'd3,
        VEC_L3    = 3'd4,
        VEC_MOD   = 3'd5,
        VEC_INV   = 3'd6,
        VEC_MULTI = 3'd7
    } miss_vec_e;

    // Vector for a lookup that found nothing at all
    function automatic miss_vec_e ctx_vector(input acc_ctx_e c);
        case (c)
            CTX_USER:   return VEC_L1U;
            CTX_KERN:   return VEC_L1K;
            CTX_NEST_U: return VEC_L2;
            default:    return VEC_L3;
        endcase
    endfunction

    function automatic logic tag_match(input tlb_ent_t e,
                                       input logic [VPN_W-1:0] vpn,
                                       input logic [ASID_W-1:0] asid);
        return (e.vpn == vpn) && (e.glob || (e.asid == asid));
    endfunction

endpackage

// File: rtl/ptlb_cam.sv
module ptlb_cam
    import ptlb_pkg::*;
#(
    parameter int NUM_ENT = 64
) (
    input  tlb_ent_t          ent   [NUM_ENT],
    input  logic [VPN_W-1:0]  vpn,
    input  logic [ASID_W-1:0] asid,
    output logic [NUM_ENT-1:0] live_hit,
    output logic [NUM_ENT-1:0] stale_hit
);
    for (genvar g = 0; g < NUM_ENT; g++) begin : g_cmp
        logic tag_eq;
        assign tag_eq       = tag_match(ent[g], vpn, asid);
        assign live_hit[g]  = tag_eq &&  ent[g].valid;
        assign stale_hit[g] = tag_eq && !ent[g].valid;
    end
endmodule

// File: rtl/ptlb_resolve.sv
module ptlb_resolve
    import ptlb_pkg::*;
#(
    parameter int NUM_ENT = 64
) (
    input  tlb_ent_t           ent [NUM_ENT],
    input  logic [NUM_ENT-1:0] live_hit,
    input  logic [NUM_ENT-1:0] stale_hit,
    input  logic               is_write,
    input  acc_ctx_e           ctx,
    output logic               hit,
    output logic [PFN_W-1:0]   pfn,
    output miss_vec_e          vec
);
    localparam int CNT_W = $clog2(NUM_ENT + 1);

    logic [CNT_W-1:0] n_live;
    logic [PFN_W-1:0] pfn_or;
    logic             dirty_or;

    // One-hot OR mux; only trusted when exactly one line is live
    always_comb begin
        n_live   = '0;
        pfn_or   = '0;
        dirty_or = 1'b0;
        for (int i = 0; i < NUM_ENT; i++) begin
            n_live   = n_live + CNT_W'(live_hit[i]);
            pfn_or   = pfn_or | (ent[i].pfn & {PFN_W{live_hit[i]}});
            dirty_or = dirty_or | (ent[i].dirty & live_hit[i]);
        end
    end

    always_comb begin
        hit = 1'b0;
        pfn = '0;
        if (n_live > CNT_W'(1)) begin
            vec = VEC_MULTI;
        end else if (n_live == CNT_W'(1)) begin
            if (is_write && !dirty_or) begin
                vec = VEC_MOD;
            end else begin
                vec = VEC_NONE;
                hit = 1'b1;
                pfn = pfn_or;
            end
        end else if (|stale_hit) begin
            vec = VEC_INV;
        end else begin
            vec = ctx_vector(ctx);
        end
    end
endmodule

// File: rtl/ptlb_victim.sv
module ptlb_victim #(
    parameter int NUM_ENT = 64,
    parameter int IDX_W   = $clog2(NUM_ENT)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] floor_idx,
    output logic [IDX_W-1:0] idx
);
    localparam logic [IDX_W-1:0] TOP = IDX_W'(NUM_ENT - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= TOP;
        end else if (idx <= floor_idx) begin
            idx <= TOP;
        end else begin
            idx <= idx - 1'b1;
        end
    end
endmodule

// File: rtl/ptlb_top.sv
module ptlb_top
    import ptlb_pkg::*;
#(
    parameter int NUM_ENT = 64
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [$clog2(NUM_ENT)-1:0] lower_slots,
    input  logic                       lk_req,
    input  logic [VPN_W-1:0]           lk_vpn,
    input  logic [ASID_W-1:0]          lk_asid,
    input  logic                       lk_write,
    input  logic [1:0]                 lk_ctx,
    input  logic                       wr_en,
    input  logic                       wr_random,
    input  logic [$clog2(NUM_ENT)-1:0] wr_idx,
    input  logic [VPN_W-1:0]           wr_vpn,
    input  logic [ASID_W-1:0]          wr_asid,
    input  logic                       wr_global,
    input  logic [PFN_W-1:0]           wr_pfn,
    input  logic                       wr_valid,
    input  logic                       wr_dirty,
    input  logic                       flush_all,
    input  logic                       flush_asid,
    input  logic [ASID_W-1:0]          flush_asid_id,
    output logic                       rsp_vld,
    output logic                       rsp_hit,
    output logic [PFN_W-1:0]           rsp_pfn,
    output logic [2:0]                 rsp_vec
);
    localparam int IDX_W = $clog2(NUM_ENT);

    tlb_ent_t           ent_q [NUM_ENT];
    logic [NUM_ENT-1:0] live_hit;
    logic [NUM_ENT-1:0] stale_hit;
    logic [NUM_ENT-1:0] valid_vec;
    logic [IDX_W-1:0]   rand_idx;
    logic [IDX_W-1:0]   tgt_idx;
    tlb_ent_t           new_ent;
    logic               c_hit;
    logic [PFN_W-1:0]   c_pfn;
    miss_vec_e          c_vec;

    ptlb_cam #(.NUM_ENT(NUM_ENT)) u_cam (
        .ent       (ent_q),
        .vpn       (lk_vpn),
        .asid      (lk_asid),
        .live_hit  (live_hit),
        .stale_hit (stale_hit)
    );

    ptlb_resolve #(.NUM_ENT(NUM_ENT)) u_res (
        .ent       (ent_q),
        .live_hit  (live_hit),
        .stale_hit (stale_hit),
        .is_write  (lk_write),
        .ctx       (acc_ctx_e'(lk_ctx)),
        .hit       (c_hit),
        .pfn       (c_pfn),
        .vec       (c_vec)
    );

    ptlb_victim #(.NUM_ENT(NUM_ENT), .IDX_W(IDX_W)) u_vic (
        .clk       (clk),
        .rst       (rst),
        .floor_idx (lower_slots),
        .idx       (rand_idx)
    );

    always_comb begin
        tgt_idx       = wr_random ? rand_idx : wr_idx;
        new_ent.vpn   = wr_vpn;
        new_ent.asid  = wr_asid;
        new_ent.glob  = wr_global;
        new_ent.pfn   = wr_pfn;
        new_ent.valid = wr_valid;
        new_ent.dirty = wr_dirty;
        for (int i = 0; i < NUM_ENT; i++) valid_vec[i] = ent_q[i].valid;
    end

    // Flushes first, then a write in the same cycle overrides its slot
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_ENT; i++) ent_q[i] <= '0;
        end else begin
            for (int i = 0; i < NUM_ENT; i++) begin
                if (flush_all ||
                    (flush_asid && !ent_q[i].glob && ent_q[i].asid == flush_asid_id))
                    ent_q[i].valid <= 1'b0;
                if (wr_en && tgt_idx == IDX_W'(i))
                    ent_q[i] <= new_ent;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_vld <= 1'b0;
            rsp_hit <= 1'b0;
            rsp_pfn <= '0;
            rsp_vec <= '0;
        end else begin
            rsp_vld <= lk_req;
            rsp_hit <= lk_req && c_hit;
            rsp_pfn <= lk_req ? c_pfn : '0;
            rsp_vec <= lk_req ? 3'(c_vec) : 3'd0;
        end
    end
endmodule

// File: rtl/ptlb_chk.sv
module ptlb_chk #(
    parameter int NUM_ENT = 64,
    parameter int IDX_W   = 6
) (
    input logic               clk,
    input logic               rst,
    input logic               lk_req,
    input logic               lk_write,
    input logic               rsp_vld,
    input logic [2:0]         rsp_vec,
    input logic [IDX_W-1:0]   lower_slots,
    input logic [IDX_W-1:0]   rand_idx,
    input logic [NUM_ENT-1:0] valid_vec,
    input logic               flush_all,
    input logic               wr_en
);
    AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (rst)
        lk_req |=> rsp_vld); // R11

    AST_RSP_IDLE: assert property (@(posedge clk) disable iff (rst)
        !lk_req |=> !rsp_vld); // R11

    AST_VICTIM_UPPER: assert property (@(posedge clk) disable iff (rst)
        (lower_slots == $past(lower_slots)) |-> (rand_idx >= lower_slots)); // R8

    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (flush_all && !wr_en) |=> (valid_vec == '0)); // R9

    AST_READ_NO_MOD: assert property (@(posedge clk) disable iff (rst)
        (lk_req && !lk_write) |=> (rsp_vec != 3'd5)); // R4
endmodule

bind ptlb_top ptlb_chk #(.NUM_ENT(NUM_ENT), .IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .lk_req      (lk_req),
    .lk_write    (lk_write),
    .rsp_vld     (rsp_vld),
    .rsp_vec     (rsp_vec),
    .lower_slots (lower_slots),
    .rand_idx    (rand_idx),
    .valid_vec   (valid_vec),
    .flush_all   (flush_all),
    .wr_en       (wr_en)
);

// File: tb/sim_ptlb_top.sv
`timescale 1ns/1ps
module sim_ptlb_top;
    localparam int N = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [5:0]  lower_slots = 6'd8;
    logic        lk_req = 0, lk_write = 0;
    logic [19:0] lk_vpn = 0;
    logic [7:0]  lk_asid = 0;
    logic [1:0]  lk_ctx = 0;
    logic        wr_en = 0, wr_random = 0, wr_global = 0, wr_valid = 0, wr_dirty = 0;
    logic [5:0]  wr_idx = 0;
    logic [19:0] wr_vpn = 0, wr_pfn = 0;
    logic [7:0]  wr_asid = 0;
    logic        flush_all = 0, flush_asid = 0;
    logic [7:0]  flush_asid_id = 0;
    logic        rsp_vld, rsp_hit;
    logic [19:0] rsp_pfn;
    logic [2:0]  rsp_vec;

    ptlb_top u0 (.*);

    // Behavioural model
    int m_vpn[N], m_asid[N], m_pfn[N];
    bit m_g[N], m_val[N], m_d[N];
    int rnd;
    bit e_vld, e_hit;
    int e_pfn, e_vec;
    string e_tag, c_tag;
    int n_chk = 0, n_bad = 0;

    // Staged stimulus for the next tick
    bit s_lk, s_w, s_wr, s_rand, s_g, s_v, s_d, s_fa, s_fs, s_rst;
    int s_vpn, s_asid, s_ctx, s_widx, s_wvpn, s_wasid, s_wpfn, s_fid;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle_stage();
        s_lk = 0; s_w = 0; s_wr = 0; s_rand = 0; s_g = 0; s_v = 0; s_d = 0;
        s_fa = 0; s_fs = 0; s_rst = 0; s_vpn = 0; s_asid = 0; s_ctx = 0;
        s_widx = 0; s_wvpn = 0; s_wasid = 0; s_wpfn = 0; s_fid = 0;
        c_tag = "R11";
    endtask

    task automatic tick();
        int nl, ns, hi, tgt;
        @(negedge clk);
        chk({e_tag, " rsp_vld"}, int'(rsp_vld), int'(e_vld));
        if (e_vld) begin
            chk({e_tag, " rsp_hit"}, int'(rsp_hit), int'(e_hit));
            chk({e_tag, " rsp_vec"}, int'(rsp_vec), e_vec);
            if (e_hit) chk({e_tag, " rsp_pfn"}, int'(rsp_pfn), e_pfn);
        end
        rst = s_rst; lk_req = s_lk; lk_vpn = 20'(s_vpn); lk_asid = 8'(s_asid);
        lk_write = s_w; lk_ctx = 2'(s_ctx); wr_en = s_wr; wr_random = s_rand;
        wr_idx = 6'(s_widx); wr_vpn = 20'(s_wvpn); wr_asid = 8'(s_wasid);
        wr_global = s_g; wr_pfn = 20'(s_wpfn); wr_valid = s_v; wr_dirty = s_d;
        flush_all = s_fa; flush_asid = s_fs; flush_asid_id = 8'(s_fid);
        e_tag = c_tag;
        if (s_rst) begin
            e_vld = 0;
            for (int i = 0; i < N; i++) begin
                m_vpn[i] = 0; m_asid[i] = 0; m_pfn[i] = 0;
                m_g[i] = 0; m_val[i] = 0; m_d[i] = 0;
            end
            rnd = N - 1;
        end else begin
            e_vld = s_lk; e_hit = 0; e_pfn = 0; e_vec = 0;
            nl = 0; ns = 0; hi = 0;
            for (int i = 0; i < N; i++) begin
                if (m_vpn[i] == s_vpn && (m_g[i] || m_asid[i] == s_asid)) begin
                    if (m_val[i]) begin nl++; hi = i; end
                    else ns++;
                end
            end
            if (nl > 1) e_vec = 7;
            else if (nl == 1) begin
                if (s_w && !m_d[hi]) e_vec = 5;
                else begin e_hit = 1; e_pfn = m_pfn[hi]; end
            end else if (ns > 0) e_vec = 6;
            else e_vec = s_ctx + 1;
            for (int i = 0; i < N; i++)
                if (s_fa || (s_fs && !m_g[i] && m_asid[i] == s_fid)) m_val[i] = 0;
            if (s_wr) begin
                tgt = s_rand ? rnd : s_widx;
                m_vpn[tgt] = s_wvpn; m_asid[tgt] = s_wasid; m_pfn[tgt] = s_wpfn;
                m_g[tgt] = s_g; m_val[tgt] = s_v; m_d[tgt] = s_d;
            end
            rnd = (rnd <= int'(lower_slots)) ? N - 1 : rnd - 1;
        end
        idle_stage();
    endtask

    task automatic look(input string tag, input int vpn, input int asid,
                        input bit w, input int ctx);
        s_lk = 1; s_vpn = vpn; s_asid = asid; s_w = w; s_ctx = ctx; c_tag = tag;
    endtask

    task automatic put(input bit rnd_sel, input int idx, input int vpn, input int asid,
                       input bit g, input int pfn, input bit v, input bit d);
        s_wr = 1; s_rand = rnd_sel; s_widx = idx; s_wvpn = vpn; s_wasid = asid;
        s_g = g; s_wpfn = pfn; s_v = v; s_d = d;
    endtask

    initial begin
        #4000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        e_vld = 0; e_tag = "R1"; rnd = N - 1;
        idle_stage();
        for (int k = 0; k < 3; k++) begin s_rst = 1; c_tag = "R1"; tick(); end
        // R1: after reset page 0 / id 0 hits only stale entries
        look("R1", 0, 0, 0, 0); tick();
        // R7 explicit writes, including a lower slot
        put(0, 3, 'h100, 1, 0, 'hAAA, 1, 1); tick();
        put(0, 20, 'h200, 0, 1, 'hBBB, 1, 0); tick();
        put(0, 40, 'h300, 2, 0, 'hCCC, 1, 1); tick();
        look("R2_R7", 'h100, 1, 0, 0); tick();
        look("R12", 'h100, 5, 0, 0); tick();
        look("R2 global", 'h200, 9, 0, 1); tick();
        look("R4", 'h200, 9, 1, 1); tick();
        look("R2 write ok", 'h300, 2, 1, 0); tick();
        for (int c = 0; c < 4; c++) begin look("R3", 'h777, 3, 0, c); tick(); end
        // R11: same-cycle write is not seen
        put(0, 5, 'h400, 1, 0, 'hDDD, 1, 1); look("R11", 'h400, 1, 0, 1); tick();
        look("R11 after", 'h400, 1, 0, 1); tick();
        put(0, 6, 'h500, 1, 0, 'h123, 0, 1); tick();
        look("R5", 'h500, 1, 0, 0); tick();
        put(0, 7, 'h100, 1, 0, 'h456, 1, 1); tick();
        look("R6", 'h100, 1, 0, 0); tick();
        s_fs = 1; s_fid = 1; tick();
        look("R10 cleared", 'h100, 1, 0, 0); tick();
        look("R10 global kept", 'h200, 1, 0, 0); tick();
        look("R10 other id kept", 'h300, 2, 0, 0); tick();
        s_fa = 1; put(0, 9, 'h600, 4, 0, 'hEEE, 1, 1); tick();
        look("R9 cleared", 'h300, 2, 0, 0); tick();
        look("R9 write kept", 'h600, 4, 0, 0); tick();
        // R8: protect lower region, then random fills
        for (int i = 0; i < 8; i++) begin put(0, i, 'h1000 + i, 3, 0, 'h50 + i, 1, 1); tick(); end
        for (int k = 0; k < 120; k++) begin put(1, 0, 'h2000 + k, 3, 0, 'h900 + k, 1, 1); tick(); end
        for (int i = 0; i < 8; i++) begin look("R8 lower kept", 'h1000 + i, 3, 0, 0); tick(); end
        for (int k = 60; k < 120; k++) begin look("R8 random", 'h2000 + k, 3, 0, 0); tick(); end
        lower_slots = 6'd4; tick(); tick();
        for (int k = 0; k < 90; k++) begin
            put(1, 0, 'h3000 + k, 3, 0, 'h700 + k, 1, 1);
            if (k % 3 == 0) look("R8 narrow", 'h3000 + k - 3, 3, 0, 0);
            tick();
        end
        for (int i = 0; i < 8; i++) begin look("R8 lower4", 'h1000 + i, 3, 0, 2); tick(); end
        lower_slots = 6'd5; tick();
        for (int k = 0; k < 70; k++) begin put(1, 0, 'h4000 + k, 3, 0, k, 1, 0); tick(); end
        for (int k = 0; k < 70; k++) begin look("R8 five", 'h4000 + k, 3, k % 2 == 1, 3); tick(); end
        tick(); tick();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule